// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Controller

This block decides, in the same cycle, where each ALU operand of a five-stage in-order integer pipeline takes its value from. It compares the two source register numbers held in the decode/execute register with the destination numbers held in the two later pipeline registers. For each operand it picks one of three values: the register-file value, the result waiting in the execute/memory register, or the result waiting in the memory/writeback register. This lets back-to-back dependent ALU instructions issue one per cycle with no stall.

The block also steers the data-memory write port. When the memory/writeback register holds a load and the instruction just behind it is a store of the register that load wrote, the loaded value goes straight to the store's write data. A load-then-store copy therefore needs no stall. The three data multiplexers are part of the block. The register file, the ALU and the load-use stall logic sit outside it. The block is purely combinational.

Top module: `fwd_unit`

## Requirements
- R1: Each operand select uses the codes 2'b00 for the register file, 2'b10 for the execute/memory result and 2'b01 for the memory/writeback result. It reads 2'b00 whenever no qualifying match exists. The code 2'b11 never appears.
- R2: An operand select is 2'b10 when that operand's source number equals the execute/memory destination, that stage's write enable is high, and the destination is not register 0.
- R3: An operand select is 2'b01 when the memory/writeback destination qualifies in the same way and the execute/memory stage does not.
- R4: When both stages qualify for the same operand, the select is 2'b10, so the younger result wins.
- R5: A stage whose register write enable is low never causes forwarding from that stage, even when its destination number matches.
- R6: A destination of register 0 never causes forwarding from any stage.
- R7: The two operand selects are decided independently. Both may bypass in the same cycle, from the same stage or from different stages.
- R8: The store-data select is 1 when all of the following hold: the memory/writeback stage holds a load (memory-to-register set and register write set); its destination is not register 0; the execute/memory stage holds a store (memory write set); and that store's data register equals the load's destination.
- R9: The store-data select is 0 when any one condition of R8 is missing. The write data is then the store's own operand.
- R10: Each data output equals the source named by its select in the same cycle: operand A and operand B from their register-file value, the execute/memory result or the memory/writeback result, and the store write data from the memory/writeback result or the store operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs | input | REG_AW | First source register of the instruction in execute |
| ex_rt | input | REG_AW | Second source register of the instruction in execute |
| mem_rd | input | REG_AW | Destination register held in the execute/memory register |
| mem_rt | input | REG_AW | Store-data register number held in the execute/memory register |
| mem_regwrite | input | 1 | Execute/memory instruction writes a register |
| mem_memwrite | input | 1 | Execute/memory instruction is a store |
| wb_rd | input | REG_AW | Destination register held in the memory/writeback register |
| wb_regwrite | input | 1 | Memory/writeback instruction writes a register |
| wb_memtoreg | input | 1 | Memory/writeback instruction is a load |
| rf_a | input | DATA_W | Register-file value for the first operand |
| rf_b | input | DATA_W | Register-file value for the second operand |
| mem_result | input | DATA_W | Result held in the execute/memory register |
| wb_result | input | DATA_W | Result held in the memory/writeback register |
| mem_store_data | input | DATA_W | Store operand carried in the execute/memory register |
| sel_a | output | 2 | Source code for operand A |
| sel_b | output | 2 | Source code for operand B |
| sel_st | output | 1 | Store write-data bypass select |
| alu_a | output | DATA_W | Operand A for the ALU |
| alu_b | output | DATA_W | Operand B for the ALU |
| st_wdata | output | DATA_W | Write data for the data memory |

## Verification
There is no register between any input and any output, so every select and data result is due in the same cycle as its stimulus. The bench applies each vector at the falling clock edge and samples one nanosecond later, well before the next rising edge. Each check therefore sees settled combinational outputs for exactly the vector just applied. The expected selects come from a stimulus table, and the expected data outputs follow from those selects and the known constant source values.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef enum logic [1:0] {
        SRC_RF  = 2'b00,
        SRC_WB  = 2'b01,
        SRC_MEM = 2'b10
    } src_sel_e;

endpackage

// File: rtl/fwd_src_pick.sv
module fwd_src_pick
    import fwd_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_we,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_we,
    output logic [1:0]        sel
);
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic mem_hit;
    logic wb_hit;

    always_comb begin
        mem_hit = mem_we && (mem_rd != ZERO_REG) && (mem_rd == src);
        wb_hit  = wb_we  && (wb_rd  != ZERO_REG) && (wb_rd  == src);
        if (mem_hit) begin
            sel = SRC_MEM;
        end else if (wb_hit) begin
            sel = SRC_WB;
        end else begin
            sel = SRC_RF;
        end
    end

    // R4
    always_comb begin
        younger_wins_chk: assert (!(mem_hit && wb_hit) || sel == SRC_MEM);
    end

endmodule

// File: rtl/fwd_store_bypass.sv
module fwd_store_bypass #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] mem_rt,
    input  logic              mem_memwrite,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_regwrite,
    input  logic              wb_memtoreg,
    output logic              sel_st
);
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic wb_is_load;

    always_comb begin
        wb_is_load = wb_memtoreg && wb_regwrite && (wb_rd != ZERO_REG);
        sel_st     = wb_is_load && mem_memwrite && (mem_rt == wb_rd);
    end

    // R9
    always_comb begin
        st_needs_store_chk: assert (!sel_st || mem_memwrite);
    end

endmodule

// File: rtl/fwd_mux3.sv
module fwd_mux3
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [DATA_W-1:0] mem_val,
    input  logic [DATA_W-1:0] wb_val,
    output logic [DATA_W-1:0] out
);
    always_comb begin
        unique case (sel)
            SRC_MEM: out = mem_val;
            SRC_WB:  out = wb_val;
            default: out = rf_val;
        endcase
    end

    // R1
    always_comb begin
        no_bad_code_chk: assert (sel != 2'b11);
    end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int REG_AW = 5,
    parameter int DATA_W = 32
) (
    input  logic [REG_AW-1:0] ex_rs,
    input  logic [REG_AW-1:0] ex_rt,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic [REG_AW-1:0] mem_rt,
    input  logic              mem_regwrite,
    input  logic              mem_memwrite,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_regwrite,
    input  logic              wb_memtoreg,
    input  logic [DATA_W-1:0] rf_a,
    input  logic [DATA_W-1:0] rf_b,
    input  logic [DATA_W-1:0] mem_result,
    input  logic [DATA_W-1:0] wb_result,
    input  logic [DATA_W-1:0] mem_store_data,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic              sel_st,
    output logic [DATA_W-1:0] alu_a,
    output logic [DATA_W-1:0] alu_b,
    output logic [DATA_W-1:0] st_wdata
);
    localparam int N_OPS = 2;

    logic [REG_AW-1:0] op_src [N_OPS];
    logic [DATA_W-1:0] op_rf  [N_OPS];
    logic [1:0]        op_sel [N_OPS];
    logic [DATA_W-1:0] op_out [N_OPS];

    assign op_src[0] = ex_rs;
    assign op_src[1] = ex_rt;
    assign op_rf[0]  = rf_a;
    assign op_rf[1]  = rf_b;

    for (genvar g = 0; g < N_OPS; g++) begin : g_op
        fwd_src_pick #(.REG_AW(REG_AW)) u_pick (
            .src    (op_src[g]),
            .mem_rd (mem_rd),
            .mem_we (mem_regwrite),
            .wb_rd  (wb_rd),
            .wb_we  (wb_regwrite),
            .sel    (op_sel[g])
        );
        fwd_mux3 #(.DATA_W(DATA_W)) u_mux (
            .sel     (op_sel[g]),
            .rf_val  (op_rf[g]),
            .mem_val (mem_result),
            .wb_val  (wb_result),
            .out     (op_out[g])
        );
    end

    fwd_store_bypass #(.REG_AW(REG_AW)) u_st (
        .mem_rt       (mem_rt),
        .mem_memwrite (mem_memwrite),
        .wb_rd        (wb_rd),
        .wb_regwrite  (wb_regwrite),
        .wb_memtoreg  (wb_memtoreg),
        .sel_st       (sel_st)
    );

    assign sel_a    = op_sel[0];
    assign sel_b    = op_sel[1];
    assign alu_a    = op_out[0];
    assign alu_b    = op_out[1];
    assign st_wdata = sel_st ? wb_result : mem_store_data;

    // R5
    always_comb begin
        wb_off_no_fwd_chk: assert (wb_regwrite || (sel_a != SRC_WB && sel_b != SRC_WB));
    end

    // R6
    always_comb begin
        mem_zero_no_fwd_chk: assert (mem_rd != '0 || (sel_a != SRC_MEM && sel_b != SRC_MEM));
    end

    // R10
    always_comb begin
        alu_a_src_chk: assert (sel_a != SRC_MEM || alu_a == mem_result);
    end

    // R8
    always_comb begin
        st_bypass_data_chk: assert (!sel_st || st_wdata == wb_result);
    end

endmodule

// File: tb/fwd_unit_test.sv
module fwd_unit_test;

    localparam int AW = 5;
    localparam int DW = 32;
    localparam logic [DW-1:0] V_RFA = 32'hA1A1_0001;
    localparam logic [DW-1:0] V_RFB = 32'hB2B2_0002;
    localparam logic [DW-1:0] V_MEM = 32'hC3C3_0003;
    localparam logic [DW-1:0] V_WB  = 32'hD4D4_0004;
    localparam logic [DW-1:0] V_SD  = 32'hE5E5_0005;

    typedef struct packed {
        logic [AW-1:0] rs;
        logic [AW-1:0] rt;
        logic [AW-1:0] mrd;
        logic [AW-1:0] mrt;
        logic          mrw;
        logic          mmw;
        logic [AW-1:0] wrd;
        logic          wrw;
        logic          wm2r;
        logic [1:0]    ea;
        logic [1:0]    eb;
        logic          est;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t TAB [NV] = '{
        '{5'd1,  5'd2,  5'd3, 5'd0,  1'b1, 1'b0, 5'd4,  1'b1, 1'b0, 2'b00, 2'b00, 1'b0}, // R1 no match
        '{5'd3,  5'd2,  5'd3, 5'd0,  1'b1, 1'b0, 5'd4,  1'b1, 1'b0, 2'b10, 2'b00, 1'b0}, // R2
        '{5'd1,  5'd4,  5'd3, 5'd0,  1'b1, 1'b0, 5'd4,  1'b1, 1'b0, 2'b00, 2'b01, 1'b0}, // R3
        '{5'd5,  5'd5,  5'd5, 5'd0,  1'b1, 1'b0, 5'd5,  1'b1, 1'b0, 2'b10, 2'b10, 1'b0}, // R4
        '{5'd6,  5'd7,  5'd6, 5'd0,  1'b0, 1'b0, 5'd7,  1'b0, 1'b0, 2'b00, 2'b00, 1'b0}, // R5
        '{5'd0,  5'd0,  5'd0, 5'd0,  1'b1, 1'b0, 5'd0,  1'b1, 1'b0, 2'b00, 2'b00, 1'b0}, // R6
        '{5'd8,  5'd9,  5'd8, 5'd0,  1'b1, 1'b0, 5'd9,  1'b1, 1'b0, 2'b10, 2'b01, 1'b0}, // R7
        '{5'd9,  5'd8,  5'd8, 5'd0,  1'b0, 1'b0, 5'd8,  1'b1, 1'b0, 2'b00, 2'b01, 1'b0}, // R5 mem off
        '{5'd2,  5'd3,  5'd0, 5'd10, 1'b0, 1'b1, 5'd10, 1'b1, 1'b1, 2'b00, 2'b00, 1'b1}, // R8
        '{5'd2,  5'd3,  5'd0, 5'd10, 1'b0, 1'b1, 5'd10, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0}, // R9 not load
        '{5'd2,  5'd3,  5'd0, 5'd10, 1'b0, 1'b0, 5'd10, 1'b1, 1'b1, 2'b00, 2'b00, 1'b0}, // R9 not store
        '{5'd2,  5'd3,  5'd0, 5'd11, 1'b0, 1'b1, 5'd10, 1'b1, 1'b1, 2'b00, 2'b00, 1'b0}, // R9 rt differs
        '{5'd2,  5'd3,  5'd0, 5'd0,  1'b0, 1'b1, 5'd0,  1'b1, 1'b1, 2'b00, 2'b00, 1'b0}, // R9 reg 0
        '{5'd2,  5'd3,  5'd0, 5'd10, 1'b0, 1'b1, 5'd10, 1'b0, 1'b1, 2'b00, 2'b00, 1'b0}, // R9 no write
        '{5'd10, 5'd10, 5'd0, 5'd10, 1'b0, 1'b1, 5'd10, 1'b1, 1'b1, 2'b01, 2'b01, 1'b1}  // R7 R8
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [AW-1:0] ex_rs, ex_rt, mem_rd, mem_rt, wb_rd;
    logic          mem_regwrite, mem_memwrite, wb_regwrite, wb_memtoreg;
    logic [DW-1:0] rf_a, rf_b, mem_result, wb_result, mem_store_data;
    logic [1:0]    sel_a, sel_b;
    logic          sel_st;
    logic [DW-1:0] alu_a, alu_b, st_wdata;

    fwd_unit #(.REG_AW(AW), .DATA_W(DW)) uut (
        .ex_rs(ex_rs), .ex_rt(ex_rt), .mem_rd(mem_rd), .mem_rt(mem_rt),
        .mem_regwrite(mem_regwrite), .mem_memwrite(mem_memwrite),
        .wb_rd(wb_rd), .wb_regwrite(wb_regwrite), .wb_memtoreg(wb_memtoreg),
        .rf_a(rf_a), .rf_b(rf_b), .mem_result(mem_result), .wb_result(wb_result),
        .mem_store_data(mem_store_data),
        .sel_a(sel_a), .sel_b(sel_b), .sel_st(sel_st),
        .alu_a(alu_a), .alu_b(alu_b), .st_wdata(st_wdata)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pick(input logic [1:0] code, input logic [DW-1:0] rf);
        case (code)
            2'b10:   return V_MEM;
            2'b01:   return V_WB;
            default: return rf;
        endcase
    endfunction

    task automatic apply(input vec_t v);
        @(negedge clk);
        ex_rs = v.rs; ex_rt = v.rt; mem_rd = v.mrd; mem_rt = v.mrt;
        mem_regwrite = v.mrw; mem_memwrite = v.mmw;
        wb_rd = v.wrd; wb_regwrite = v.wrw; wb_memtoreg = v.wm2r;
        #1;
    endtask

    initial begin
        ex_rs = '0; ex_rt = '0; mem_rd = '0; mem_rt = '0; wb_rd = '0;
        mem_regwrite = 1'b0; mem_memwrite = 1'b0; wb_regwrite = 1'b0; wb_memtoreg = 1'b0;
        rf_a = V_RFA; rf_b = V_RFB; mem_result = V_MEM; wb_result = V_WB; mem_store_data = V_SD;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R1 idle state: all inputs quiet, everything from the register file
        chk("R1 idle sel_a", {30'd0, sel_a}, 32'd0);
        chk("R1 idle sel_b", {30'd0, sel_b}, 32'd0);
        chk("R9 idle sel_st", {31'd0, sel_st}, 32'd0);
        chk("R10 idle st_wdata", st_wdata, V_SD);

        for (int i = 0; i < NV; i++) begin
            apply(TAB[i]);
            chk($sformatf("R1-table %0d sel_a", i), {30'd0, sel_a}, {30'd0, TAB[i].ea});
            chk($sformatf("R7 table %0d sel_b", i), {30'd0, sel_b}, {30'd0, TAB[i].eb});
            chk($sformatf("R8 table %0d sel_st", i), {31'd0, sel_st}, {31'd0, TAB[i].est});
            chk($sformatf("R10 table %0d alu_a", i), alu_a, pick(TAB[i].ea, V_RFA));
            chk($sformatf("R10 table %0d alu_b", i), alu_b, pick(TAB[i].eb, V_RFB));
            chk($sformatf("R10 table %0d st_wdata", i), st_wdata, TAB[i].est ? V_WB : V_SD);
        end

        // R10 data follows a change of source value in the same cycle
        @(negedge clk);
        ex_rs = 5'd12; mem_rd = 5'd12; mem_regwrite = 1'b1; wb_rd = 5'd0;
        mem_result = 32'h1234_5678;
        #1;
        chk("R10 live mem_result", alu_a, 32'h1234_5678);
        // R4 double match with different data picks the younger value
        @(negedge clk);
        wb_rd = 5'd12; wb_regwrite = 1'b1; wb_result = 32'h0BAD_0BAD;
        #1;
        chk("R4 live younger", alu_a, 32'h1234_5678);
        // R3 once the younger stage stops writing, the older one supplies it
        @(negedge clk);
        mem_regwrite = 1'b0;
        #1;
        chk("R3 live older", alu_a, 32'h0BAD_0BAD);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule